// File: doc/BRIEF.md
# DDS Trajectory Profile Player

The player turns a queue of motion segments into two sinusoidal phase-current references for a two-phase motor drive. Each segment carries a signed acceleration and a count of update ticks. A velocity accumulator adds the active acceleration on every tick. A phase accumulator adds the velocity on every tick. The top bits of the phase address a sine table, and a second read of the same table a quarter period further on gives the cosine. Both samples are scaled by a current amplitude and then registered as the references that the two current loops follow.

Segments are written into a small FIFO that sits ahead of the integrators. The tick input is normally strobed once per PWM period, so each current loop gets a fresh reference on every cycle. A velocity profile of any shape is built by chaining segments. When the queue runs dry, acceleration drops to zero and the motor keeps turning at its last velocity.

Top module: `dds_profile_player`

## Requirements
- R1: While `rst` is high at a clock edge, the design clears the FIFO, velocity, phase, the active segment and both references. After that edge, `ref_sin`, `ref_cos`, `busy` and `seg_full` read 0.
- R2: A write (`seg_wr` high) is accepted when `seg_full` was low before the edge. Up to FIFO_DEPTH (default 8) segments are held and played in write order. `seg_full` is high exactly while FIFO_DEPTH segments are queued. A write made while `seg_full` is high is dropped, even if a pop happens in the same cycle.
- R3: On a tick with no active segment (remaining count 0) and a non-empty FIFO, the oldest segment is popped and loaded, and velocity does not change on that tick. On each of the next N ticks the segment's acceleration is added to velocity, where N is its tick count. A segment with N = 0 adds nothing.
- R4: On a tick with no active segment and an empty FIFO, velocity is held and phase keeps advancing by that velocity.
- R5: Velocity is a 24-bit two's-complement value that wraps on overflow. On each tick, phase (32 bits, unsigned, modulo 2^32) adds the sign-extended velocity as it stood before the tick, so a negative velocity makes the phase decrease. Velocity and phase do not change in a cycle where `tick` is low.
- R6: Table entry k (k = 0..255) equals round(2047 * sin(2*pi*k/256)), with rounding half up. The sine index is phase bits [31:24]. The cosine index is that value plus 64, modulo 256.
- R7: Each reference equals floor((s * amp + 1024) / 2048), where s is the signed table sample and `amp` is unsigned, so amp = 2048 is unity gain. The result saturates to the range -2048..2047.
- R8: The references are registered. The values seen after a clock edge come from the phase and `amp` present before that edge.
- R9: `busy` is high exactly while a segment has ticks remaining or the FIFO is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr | input | 1 | Segment write strobe |
| seg_accel | input | 24 | Signed acceleration of the segment being written |
| seg_ticks | input | 16 | Number of ticks the segment applies |
| seg_full | output | 1 | FIFO holds FIFO_DEPTH segments |
| tick | input | 1 | Update enable, one pulse per PWM period |
| amp | input | 12 | Unsigned current amplitude, 2048 = unity |
| ref_sin | output | 12 | Signed reference for phase A |
| ref_cos | output | 12 | Signed reference for phase B |
| busy | output | 1 | Segment active or FIFO non-empty |

## Verification
A corrupted velocity or phase register is not visible on the spot. A velocity error shows up as a slowly growing drift in the rate at which the references move around the circle, and only once the phase carries past a table index boundary, which can take tens of ticks at low speed. A segment loaded one tick early or late, or with the wrong count, leaves a permanent phase offset, and the references disagree with a per-cycle reference model from the next index crossing onward. Scaling and saturation faults appear in the cycle right after the edge, so amplitude steps and zero-phase points after reset are checked directly.

// File: rtl/dds_pkg.sv
package dds_pkg;

   // Rounded sine sample for table position idx of a 2**idx_w entry table,
   // peak amplitude 2**(smp_w-1)-1.
   function automatic int sine_code(input int idx, input int idx_w, input int smp_w);
      real ang;
      real pk;
      ang = 6.283185307179586 * idx / (2.0 ** idx_w);
      pk  = (2.0 ** (smp_w - 1)) - 1.0;
      return $rtoi($floor(pk * $sin(ang) + 0.5));
   endfunction

endpackage

// File: rtl/seg_fifo.sv
module seg_fifo #(
   parameter int DATA_W = 40,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty
);
   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int FILL_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("seg_fifo: DEPTH must be at least 1");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [FILL_W-1:0] fill;
   logic              push;

   assign full    = (fill == FILL_W'(DEPTH));
   assign empty   = (fill == '0);
   assign push    = wr_en && !full;
   assign rd_data = mem[rd_ptr];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push)  wr_ptr <= bump(wr_ptr);
         if (rd_en) rd_ptr <= bump(rd_ptr);
         fill <= fill + FILL_W'(push) - FILL_W'(rd_en);
      end
   end

   // R2
   drop_when_full_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && full && !rd_en) |=> (full && $stable(wr_ptr)));

   // R2
   no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> !empty);

endmodule

// File: rtl/traj_integrator.sv
module traj_integrator #(
   parameter int ACC_W = 24,
   parameter int VEL_W = 24,
   parameter int PH_W  = 32,
   parameter int CNT_W = 16,
   parameter int IDX_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    tick,
   input  logic                    seg_avail,
   input  logic signed [ACC_W-1:0] seg_acc,
   input  logic [CNT_W-1:0]        seg_cnt,
   output logic                    seg_pop,
   output logic                    active,
   output logic [IDX_W-1:0]        idx
);
   if (ACC_W > VEL_W) begin : g_bad_acc
      $error("traj_integrator: ACC_W must not exceed VEL_W");
   end
   if (VEL_W > PH_W || IDX_W > PH_W) begin : g_bad_ph
      $error("traj_integrator: PH_W must cover VEL_W and IDX_W");
   end

   logic signed [ACC_W-1:0] acc_q;
   logic [CNT_W-1:0]        left_q;
   logic signed [VEL_W-1:0] vel_q;
   logic [PH_W-1:0]         ph_q;
   logic signed [VEL_W-1:0] acc_ext;
   logic [PH_W-1:0]         vel_ext;

   assign acc_ext = VEL_W'(acc_q);
   assign vel_ext = PH_W'(vel_q);
   assign active  = (left_q != '0);
   assign seg_pop = tick && !active && seg_avail;
   assign idx     = ph_q[PH_W-1 -: IDX_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         left_q <= '0;
         vel_q  <= '0;
         ph_q   <= '0;
      end else if (tick) begin
         ph_q <= ph_q + vel_ext;
         if (active) begin
            vel_q  <= vel_q + acc_ext;
            left_q <= left_q - CNT_W'(1);
         end else if (seg_avail) begin
            acc_q  <= seg_acc;
            left_q <= seg_cnt;
         end
      end
   end

   // R3
   load_no_accel_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && !active && seg_avail) |=> ((left_q == $past(seg_cnt)) && (vel_q == $past(vel_q))));

   // R4
   idle_hold_vel_chk: assert property (@(posedge clk) disable iff (rst)
      (tick && !active && !seg_avail) |=> (vel_q == $past(vel_q)));

   // R5
   no_tick_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(vel_q) && $stable(ph_q) && $stable(left_q)));

endmodule

// File: rtl/sine_lut.sv
module sine_lut #(
   parameter int IDX_W = 8,
   parameter int SMP_W = 12
) (
   input  logic [IDX_W-1:0]        idx,
   output logic signed [SMP_W-1:0] sin_val,
   output logic signed [SMP_W-1:0] cos_val
);
   localparam int N   = 1 << IDX_W;
   localparam int QTR = N / 4;

   if (IDX_W < 2) begin : g_bad_idx
      $error("sine_lut: IDX_W must be at least 2");
   end

   logic signed [SMP_W-1:0] rom [N];
   logic [IDX_W-1:0]        cos_idx;

   for (genvar i = 0; i < N; i++) begin : g_rom
      localparam int V = dds_pkg::sine_code(i, IDX_W, SMP_W);
      assign rom[i] = SMP_W'(V);
   end

   assign cos_idx = idx + IDX_W'(QTR);
   assign sin_val = rom[idx];
   assign cos_val = rom[cos_idx];

endmodule

// File: rtl/ref_scaler.sv
module ref_scaler #(
   parameter int SMP_W = 12,
   parameter int AMP_W = 12,
   parameter bit ROUND = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [SMP_W-1:0] sample,
   input  logic [AMP_W-1:0]        amp,
   output logic signed [SMP_W-1:0] ref_q
);
   localparam int PROD_W = SMP_W + AMP_W + 1;
   localparam int SHIFT  = AMP_W - 1;
   localparam logic signed [PROD_W-1:0] HI   = PROD_W'(2 ** (SMP_W - 1) - 1);
   localparam logic signed [PROD_W-1:0] LO   = ~HI;
   localparam logic signed [PROD_W-1:0] HALF = PROD_W'(2 ** (SHIFT - 1));

   if (AMP_W < 2) begin : g_bad_amp
      $error("ref_scaler: AMP_W must be at least 2");
   end

   logic signed [PROD_W-1:0] s_ext, a_ext, prod, rnd, shf;
   logic signed [SMP_W-1:0]  sat;

   assign s_ext = PROD_W'(sample);
   assign a_ext = $signed(PROD_W'(amp));
   assign prod  = s_ext * a_ext;

   if (ROUND) begin : g_round
      assign rnd = prod + HALF;
   end else begin : g_trunc
      assign rnd = prod;
   end

   assign shf = rnd >>> SHIFT;

   always_comb begin
      if (shf > HI)      sat = HI[SMP_W-1:0];
      else if (shf < LO) sat = LO[SMP_W-1:0];
      else               sat = shf[SMP_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) ref_q <= '0;
      else     ref_q <= sat;
   end

   // R7
   zero_amp_chk: assert property (@(posedge clk) disable iff (rst)
      (amp == '0) |=> (ref_q == '0));

endmodule

// File: rtl/dds_profile_player.sv
module dds_profile_player #(
   parameter int ACC_W      = 24,
   parameter int VEL_W      = 24,
   parameter int PH_W       = 32,
   parameter int CNT_W      = 16,
   parameter int FIFO_DEPTH = 8,
   parameter int IDX_W      = 8,
   parameter int SMP_W      = 12,
   parameter int AMP_W      = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    seg_wr,
   input  logic signed [ACC_W-1:0] seg_accel,
   input  logic [CNT_W-1:0]        seg_ticks,
   output logic                    seg_full,
   input  logic                    tick,
   input  logic [AMP_W-1:0]        amp,
   output logic signed [SMP_W-1:0] ref_sin,
   output logic signed [SMP_W-1:0] ref_cos,
   output logic                    busy
);
   typedef struct packed {
      logic signed [ACC_W-1:0] accel;
      logic [CNT_W-1:0]        ticks;
   } seg_t;

   localparam int SEG_W = $bits(seg_t);

   seg_t                    wr_seg, rd_seg;
   logic                    fifo_empty, seg_pop, seg_active;
   logic [IDX_W-1:0]        idx;
   logic signed [SMP_W-1:0] sin_s, cos_s;

   assign wr_seg.accel = seg_accel;
   assign wr_seg.ticks = seg_ticks;
   assign busy         = seg_active || !fifo_empty;

   seg_fifo #(.DATA_W(SEG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .wr_en(seg_wr), .wr_data(wr_seg),
      .rd_en(seg_pop), .rd_data(rd_seg),
      .full(seg_full), .empty(fifo_empty)
   );

   traj_integrator #(.ACC_W(ACC_W), .VEL_W(VEL_W), .PH_W(PH_W),
                     .CNT_W(CNT_W), .IDX_W(IDX_W)) u_integ (
      .clk(clk), .rst(rst), .tick(tick),
      .seg_avail(!fifo_empty), .seg_acc(rd_seg.accel), .seg_cnt(rd_seg.ticks),
      .seg_pop(seg_pop), .active(seg_active), .idx(idx)
   );

   sine_lut #(.IDX_W(IDX_W), .SMP_W(SMP_W)) u_lut (
      .idx(idx), .sin_val(sin_s), .cos_val(cos_s)
   );

   ref_scaler #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_scale_a (
      .clk(clk), .rst(rst), .sample(sin_s), .amp(amp), .ref_q(ref_sin)
   );

   ref_scaler #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_scale_b (
      .clk(clk), .rst(rst), .sample(cos_s), .amp(amp), .ref_q(ref_cos)
   );

   // R9
   full_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
      seg_full |-> busy);

endmodule

// File: tb/dds_profile_player_bench.sv
`timescale 1ns/1ps
module dds_profile_player_bench;
   localparam int DEPTH = 8;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               seg_wr = 1'b0;
   logic signed [23:0] seg_accel = '0;
   logic [15:0]        seg_ticks = '0;
   logic               tick = 1'b0;
   logic [11:0]        amp = 12'd2048;
   logic               seg_full, busy;
   logic signed [11:0] ref_sin, ref_cos;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dds_profile_player u_dds_profile_player (
      .clk(clk), .rst(rst), .seg_wr(seg_wr), .seg_accel(seg_accel),
      .seg_ticks(seg_ticks), .seg_full(seg_full), .tick(tick), .amp(amp),
      .ref_sin(ref_sin), .ref_cos(ref_cos), .busy(busy)
   );

   // behavioural model state
   longint m_ph, m_vel;
   int     m_acc, m_left, m_sin, m_cos;
   int     qa[$];
   int     qc[$];

   function automatic int samp(input int k);
      return $rtoi($floor(2047.0 * $sin(6.283185307179586 * k / 256.0) + 0.5));
   endfunction

   function automatic int scale(input int s, input int a);
      longint p, r;
      p = longint'(s) * a + 1024;
      if (p >= 0) r = p / 2048;
      else        r = -((-p + 2047) / 2048);
      if (r > 2047)  r = 2047;
      if (r < -2048) r = -2048;
      return int'(r);
   endfunction

   function automatic longint wrap24(input longint v);
      longint w;
      w = v & 64'hFF_FFFF;
      if (w >= 64'sh80_0000) w = w - 64'sh100_0000;
      return w;
   endfunction

   task automatic model_step();
      int k;
      bit room;
      if (rst) begin
         m_ph = 0; m_vel = 0; m_acc = 0; m_left = 0; m_sin = 0; m_cos = 0;
         qa.delete(); qc.delete();
      end else begin
         k = int'(m_ph >> 24);
         m_sin = scale(samp(k), int'(amp));
         m_cos = scale(samp((k + 64) % 256), int'(amp));
         room = (qa.size() < DEPTH);
         if (tick) begin
            m_ph = (m_ph + m_vel) & 64'hFFFF_FFFF;
            if (m_left > 0) begin
               m_vel = wrap24(m_vel + m_acc);
               m_left--;
            end else if (qa.size() > 0) begin
               m_acc  = qa.pop_front();
               m_left = qc.pop_front();
            end
         end
         if (seg_wr && room) begin
            qa.push_back(int'(seg_accel));
            qc.push_back(int'(seg_ticks));
         end
      end
   endtask

   task automatic chk(input string tag, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R3 R4 R5 R6 R7 R8 ref_sin", ref_sin, m_sin);
      chk("R3 R4 R5 R6 R7 R8 ref_cos", ref_cos, m_cos);
      chk("R9 busy", busy, ((m_left != 0) || (qa.size() != 0)) ? 1 : 0);
      chk("R2 seg_full", seg_full, (qa.size() == DEPTH) ? 1 : 0);
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic put(input int a, input int c);
      seg_wr = 1'b1;
      seg_accel = 24'(a);
      seg_ticks = 16'(c);
      cyc();
      seg_wr = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      rst = 1'b1; amp = 12'd4095;
      cyc(); cyc();
      // R1 reset state
      chk("R1 ref_sin after reset", ref_sin, 0);
      chk("R1 ref_cos after reset", ref_cos, 0);
      chk("R1 busy after reset", busy, 0);
      chk("R1 seg_full after reset", seg_full, 0);
      rst = 1'b0;
      cyc();
      // R7 saturation: cos sample 2047 times gain ~2 clamps to 2047
      chk("R7 saturated ref_cos", ref_cos, 2047);
      chk("R6 ref_sin at phase zero", ref_sin, 0);
      amp = 12'd1024;
      cyc();
      chk("R7 half gain ref_cos", ref_cos, 1024);
      amp = 12'd0;
      cyc();
      chk("R7 zero amplitude ref_cos", ref_cos, 0);
      amp = 12'd2048;
      cyc();
      chk("R8 R7 unity ref_cos", ref_cos, 2047);

      // R2 fill the queue with ticks held low, two extra writes are dropped
      put(40000, 100);
      put(0, 150);
      put(-40000, 100);
      put(-60000, 100);
      put(0, 100);
      put(60000, 100);
      put(999, 0);
      put(8000000, 3);
      chk("R2 full after depth writes", seg_full, 1);
      put(123, 5);
      put(456, 7);
      chk("R2 still full after dropped writes", seg_full, 1);

      // R3 R5 play back with a tick every cycle, refilling occasionally
      tick = 1'b1;
      for (int i = 0; i < 900; i++) begin
         if (i % 60 == 20) put((i % 7) * 3000 - 9000, 25);
         else cyc();
      end

      // R5 sparse ticks with changing amplitude
      for (int i = 0; i < 300; i++) begin
         tick = (i % 3 == 0);
         amp = 12'((i * 37) % 4096);
         cyc();
      end
      amp = 12'd3000;

      // R4 drain the queue, then coast at the held velocity
      tick = 1'b1;
      for (int i = 0; i < 4000 && busy; i++) cyc();
      chk("R9 busy low after drain", busy, 0);
      for (int i = 0; i < 200; i++) cyc();
      chk("R4 idle coast keeps busy low", busy, 0);

      // R1 reset in mid motion
      put(50000, 10);
      rst = 1'b1;
      cyc();
      chk("R1 ref_sin after mid reset", ref_sin, 0);
      chk("R1 busy after mid reset", busy, 0);
      rst = 1'b0;
      for (int i = 0; i < 20; i++) cyc();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired exp=finish got=hang");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule